// File: doc/BRIEF.md
# Integer ALU with Registered Condition Flags

This block is a width-parameterised integer arithmetic and logic unit with a small condition-flag register beside it. A 4-bit operation code picks one of fifteen functions on two operand words. The functions are add and subtract, each with and without an incoming carry or borrow, negate, pass-through, the four bitwise logic functions, three single-bit shifts and two rotates through carry. The result word and five flags (carry, zero, negative, overflow, parity) come out combinationally in the same cycle as the operands.

A clocked status word captures the five flags on a rising edge when the flag write enable is high. The carry bit it holds is the carry-in, or borrow-in, for the next operation. A surrounding datapath can therefore chain multi-word arithmetic, or run a subtract purely for its flags as a compare, without any extra state of its own.

Top module: `alu_status_core`

## Requirements
- R1: Opcode 0 (add) gives Y = A + B, and opcode 1 (add with carry) gives Y = A + B + stored C. For both, the carry flag is the unsigned carry out of the top bit, and overflow is set when two operands of equal sign give a result of the opposite sign.
- R2: Opcode 2 (subtract) gives Y = A − B, and opcode 3 (subtract with borrow) gives Y = A − B − stored C. For both, the carry flag is a borrow: it is 1 exactly when the unsigned minuend is smaller than the amount subtracted. Overflow is set on signed out-of-range differences.
- R3: Opcode 4 gives Y = 0 − A, with carry set as a borrow (1 whenever A ≠ 0) and overflow set only when A is the most negative value. Opcode 5 gives Y = A with carry and overflow 0.
- R4: Opcodes 6, 7 and 8 give A AND B, A OR B and A XOR B, and opcode 9 gives NOT A. All four force carry and overflow to 0.
- R5: Opcode 10 shifts A left by one and inserts 0; the carry flag takes the old top bit, and overflow is 1 when the sign of Y differs from the sign of A. Opcode 11 (logical right) inserts 0, and opcode 12 (arithmetic right) keeps the sign bit; both put the old bit 0 in carry and clear overflow.
- R6: Opcode 13 rotates A left, putting stored C into bit 0 and the old top bit into carry. Opcode 14 rotates A right, putting stored C into the top bit and the old bit 0 into carry. Overflow is 0 for both.
- R7: The zero flag is 1 when every bit of Y is 0. The negative flag equals the top bit of Y. The parity flag is 1 when Y holds an even number of 1 bits.
- R8: The status word is {C, Z, N, V, P}, with C in bit 4 and P in bit 0. On a rising edge with the write enable high it loads the current flags. With the enable low it keeps its value.
- R9: With reset high at a rising edge, the status word becomes all zeros (synchronous reset), and it has priority over the write enable.
- R10: Opcode 15 is unassigned. It gives Y = 0 with carry and overflow 0, so zero and parity read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the status word |
| rst | input | 1 | Synchronous active-high reset of the status word |
| op | input | 4 | Operation select |
| a | input | W | First operand |
| b | input | W | Second operand |
| flag_we | input | 1 | Load the status word with the current flags |
| y | output | W | Result word |
| c_out | output | 1 | Carry / borrow / shifted-out bit of the current operation |
| z_out | output | 1 | Current zero flag |
| n_out | output | 1 | Current negative flag |
| v_out | output | 1 | Current signed overflow flag |
| p_out | output | 1 | Current even-parity flag |
| status | output | 5 | Registered {C, Z, N, V, P}; bit 4 is the carry-in |

## Verification
The bench targets the places where carry conventions usually go wrong. Subtract with borrow at 0x80 − 0 − 1 catches a design that treats the raw adder carry as the borrow, which would report carry 1 and miss the signed overflow. Negating zero and negating the most negative value pin the borrow and overflow ends of negate. A rotate run with a carry loaded one cycle before exposes a design that feeds the rotate from the live carry rather than the stored bit, or that inserts 0. Every opcode is also swept over 0, all ones and both signed extremes with both carry-in values, and write-enable-low cycles confirm that a design updating the flags unconditionally is seen at the status port.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_NEG  = 4'd4,
        OP_PASS = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOT  = 4'd9,
        OP_SHL  = 4'd10,
        OP_SHR  = 4'd11,
        OP_SAR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_NONE
    } op_class_e;

    // Status word layout: C in bit 4 down to P in bit 0.
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic p;
    } flags_t;

    localparam int FLAG_BITS = $bits(flags_t);

    function automatic op_class_e classify(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG: return CLS_ARITH;
            OP_PASS, OP_AND, OP_OR, OP_XOR, OP_NOT: return CLS_LOGIC;
            OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR: return CLS_SHIFT;
            default:                                return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           c,
    output logic           v
);
    localparam int MSB = W - 1;

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic         ci;
    logic         borrow_mode;
    logic [W:0]   sum;

    always_comb begin
        opa         = a;
        opb         = b;
        ci          = 1'b0;
        borrow_mode = 1'b0;
        case (op)
            OP_ADC: ci = cin;
            OP_SUB: begin
                opb         = ~b;
                ci          = 1'b1;
                borrow_mode = 1'b1;
            end
            OP_SBB: begin
                opb         = ~b;
                ci          = ~cin;
                borrow_mode = 1'b1;
            end
            OP_NEG: begin
                opa         = '0;
                opb         = ~a;
                ci          = 1'b1;
                borrow_mode = 1'b1;
            end
            default: ;
        endcase
        sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
        y   = sum[W-1:0];
        // Subtractions report borrow, the inverse of the adder carry.
        c   = sum[W] ^ borrow_mode;
        v   = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           c,
    output logic           v
);
    localparam int MSB = W - 1;

    logic left;
    logic fill;

    always_comb begin
        left = (op == OP_SHL) || (op == OP_ROL);
        case (op)
            OP_SAR:          fill = a[MSB];
            OP_ROL, OP_ROR:  fill = cin;
            default:         fill = 1'b0;
        endcase
        if (left) begin
            y = {a[MSB-1:0], fill};
            c = a[MSB];
        end else begin
            y = {fill, a[MSB:1]};
            c = a[0];
        end
        v = (op == OP_SHL) && (y[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           op,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 flag_we,
    output logic [W-1:0]         y,
    output logic                 c_out,
    output logic                 z_out,
    output logic                 n_out,
    output logic                 v_out,
    output logic                 p_out,
    output logic [FLAG_BITS-1:0] status
);
    alu_op_e   op_e;
    op_class_e cls;
    flags_t    now_f;
    flags_t    st_q;

    logic [W-1:0] ar_y, lg_y, sh_y;
    logic         ar_c, ar_v, sh_c, sh_v;

    assign op_e = alu_op_e'(op);
    assign cls  = classify(op_e);

    alu_arith #(.W(W)) u_arith (
        .op  (op_e),
        .a   (a),
        .b   (b),
        .cin (st_q.c),
        .y   (ar_y),
        .c   (ar_c),
        .v   (ar_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op (op_e),
        .a  (a),
        .b  (b),
        .y  (lg_y)
    );

    alu_shift #(.W(W)) u_shift (
        .op  (op_e),
        .a   (a),
        .cin (st_q.c),
        .y   (sh_y),
        .c   (sh_c),
        .v   (sh_v)
    );

    always_comb begin
        now_f = '0;
        case (cls)
            CLS_ARITH: begin y = ar_y; now_f.c = ar_c; now_f.v = ar_v; end
            CLS_SHIFT: begin y = sh_y; now_f.c = sh_c; now_f.v = sh_v; end
            CLS_LOGIC: y = lg_y;
            default:   y = '0;
        endcase
        now_f.z = (y == '0);
        now_f.n = y[W-1];
        now_f.p = ~^y;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (flag_we)
            st_q <= now_f;
    end

    assign c_out  = now_f.c;
    assign z_out  = now_f.z;
    assign n_out  = now_f.n;
    assign v_out  = now_f.v;
    assign p_out  = now_f.p;
    assign status = st_q;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op,
    input logic [W-1:0] a,
    input logic         flag_we,
    input logic [W-1:0] y,
    input logic         c_out,
    input logic         z_out,
    input logic         n_out,
    input logic         v_out,
    input logic         p_out,
    input logic [4:0]   status
);
    // R9
    reset_clear_chk: assert property (@(posedge clk) rst |=> status == 5'd0);

    // R8
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> status == $past({c_out, z_out, n_out, v_out, p_out}));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(status));

    // R4
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd5 && op <= 4'd9) |-> (!c_out && !v_out));

    // R3
    pass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        op == 4'd5 |-> y == a);

    // R6
    rol_fill_chk: assert property (@(posedge clk) disable iff (rst)
        op == 4'd13 |-> (y[0] == status[4] && c_out == a[W-1]));

    // R6
    ror_fill_chk: assert property (@(posedge clk) disable iff (rst)
        op == 4'd14 |-> (y[W-1] == status[4] && c_out == a[0]));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        z_out == (y == '0));

    // R10
    rsvd_op_chk: assert property (@(posedge clk) disable iff (rst)
        op == 4'd15 |-> (y == '0 && !c_out && !v_out && p_out));

endmodule

bind alu_status_core alu_status_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_status_core.sv
module tb_alu_status_core;
    localparam int W = 8;
    localparam int NVEC = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op = '0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         flag_we = 1'b0;
    logic [W-1:0] y;
    logic         c_out, z_out, n_out, v_out, p_out;
    logic [4:0]   status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alu_status_core #(.W(W)) dut (
        .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .flag_we(flag_we),
        .y(y), .c_out(c_out), .z_out(z_out), .n_out(n_out),
        .v_out(v_out), .p_out(p_out), .status(status)
    );

    always #2 clk = ~clk;

    // {op, a, b, cin, expected y, expected {C,Z,N,V,P}}
    localparam logic [33:0] VEC [NVEC] = '{
        {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 5'b00110},
        {4'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 5'b11001},
        {4'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 5'b10100},
        {4'd3,  8'h80, 8'h00, 1'b1, 8'h7F, 5'b00010},
        {4'd4,  8'h80, 8'h00, 1'b0, 8'h80, 5'b10110},
        {4'd4,  8'h00, 8'h00, 1'b1, 8'h00, 5'b01001},
        {4'd10, 8'hC1, 8'h00, 1'b0, 8'h82, 5'b10101},
        {4'd10, 8'h40, 8'h00, 1'b0, 8'h80, 5'b00110},
        {4'd12, 8'h81, 8'h00, 1'b0, 8'hC0, 5'b10101},
        {4'd11, 8'h81, 8'h00, 1'b1, 8'h40, 5'b10000},
        {4'd13, 8'h80, 8'h00, 1'b1, 8'h01, 5'b10000},
        {4'd14, 8'h01, 8'h00, 1'b0, 8'h00, 5'b11001},
        {4'd6,  8'hF0, 8'h3C, 1'b1, 8'h30, 5'b00001},
        {4'd8,  8'hFF, 8'hFF, 1'b0, 8'h00, 5'b01001},
        {4'd9,  8'h0F, 8'h00, 1'b1, 8'hF0, 5'b00101},
        {4'd5,  8'h80, 8'h55, 1'b0, 8'h80, 5'b00100},
        {4'd7,  8'h00, 8'h00, 1'b1, 8'h00, 5'b01001},
        {4'd15, 8'hAA, 8'h55, 1'b1, 8'h00, 5'b01001}
    };

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0, 4'd1:                 return "R1";
            4'd2, 4'd3:                 return "R2";
            4'd4, 4'd5:                 return "R3";
            4'd6, 4'd7, 4'd8, 4'd9:     return "R4";
            4'd10, 4'd11, 4'd12:        return "R5";
            4'd13, 4'd14:               return "R6";
            default:                    return "R10";
        endcase
    endfunction

    // Independent reference: returns {y, C, V}; Z, N, P come from y.
    function automatic logic [W+1:0] ref_model(logic [3:0] o, logic [7:0] x,
                                               logic [7:0] z, logic ci);
        int sa, sb, s;
        int ua, ub, u;
        logic [7:0] r;
        logic cf, vf;
        sa = $signed(x); sb = $signed(z); ua = x; ub = z;
        cf = 1'b0; vf = 1'b0; r = 8'h00;
        case (o)
            4'd0, 4'd1: begin
                u = ua + ub + ((o == 4'd1) ? int'(ci) : 0);
                s = sa + sb + ((o == 4'd1) ? int'(ci) : 0);
                r = u[7:0]; cf = (u > 255); vf = (s > 127 || s < -128);
            end
            4'd2, 4'd3: begin
                u = ua - ub - ((o == 4'd3) ? int'(ci) : 0);
                s = sa - sb - ((o == 4'd3) ? int'(ci) : 0);
                r = u[7:0]; cf = (u < 0); vf = (s > 127 || s < -128);
            end
            4'd4: begin
                s = -sa; r = s[7:0]; cf = (ua != 0); vf = (s > 127);
            end
            4'd5:  r = x;
            4'd6:  r = x & z;
            4'd7:  r = x | z;
            4'd8:  r = x ^ z;
            4'd9:  r = ~x;
            4'd10: begin r = {x[6:0], 1'b0}; cf = x[7]; vf = x[7] ^ x[6]; end
            4'd11: begin r = {1'b0, x[7:1]}; cf = x[0]; end
            4'd12: begin r = {x[7], x[7:1]}; cf = x[0]; end
            4'd13: begin r = {x[6:0], ci}; cf = x[7]; end
            4'd14: begin r = {ci, x[7:1]}; cf = x[0]; end
            default: r = 8'h00;
        endcase
        return {r, cf, vf};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Loads the stored carry through an add with the write enable high.
    task automatic set_carry(logic ci);
        @(negedge clk);
        op = 4'd0; a = ci ? 8'hFF : 8'h00; b = ci ? 8'h01 : 8'h00; flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic run_ref(logic [3:0] o, logic [7:0] x, logic [7:0] z, logic ci);
        logic [W+1:0] e;
        logic [7:0] ey;
        logic [4:0] ef;
        set_carry(ci);
        op = o; a = x; b = z;
        #1;
        e  = ref_model(o, x, z, ci);
        ey = e[W+1:2];
        ef = {e[1], ey == 8'h00, ey[7], e[0], ~^ey};
        check(req_of(o), {24'd0, y}, {24'd0, ey}, "result");
        check("R7", {27'd0, c_out, z_out, n_out, v_out, p_out}, {27'd0, ef}, "flags");
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] edges [4];
        edges[0] = 8'h00; edges[1] = 8'hFF; edges[2] = 8'h80; edges[3] = 8'h7F;

        // R9: synchronous reset clears the status word
        repeat (2) @(negedge clk);
        flag_we = 1'b1; op = 4'd15;
        @(negedge clk);
        check("R9", {27'd0, status}, 32'd0, "status after reset");
        rst = 1'b0; flag_we = 1'b0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            v = VEC[i];
            set_carry(v[13]);
            op = v[33:30]; a = v[29:22]; b = v[21:14];
            #1;
            check(req_of(v[33:30]), {24'd0, y}, {24'd0, v[12:5]}, "result");
            check("R7", {27'd0, c_out, z_out, n_out, v_out, p_out}, {27'd0, v[4:0]}, "flags");
        end

        // R8: load on enable, then hold while enable low
        @(negedge clk);
        op = 4'd2; a = 8'h05; b = 8'h07; flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
        check("R8", {27'd0, status}, {27'd0, 5'b10100}, "status loaded");
        op = 4'd5; a = 8'h00;
        repeat (3) @(negedge clk);
        check("R8", {27'd0, status}, {27'd0, 5'b10100}, "status held");

        // R8: stored carry drives add-with-carry
        op = 4'd1; a = 8'h10; b = 8'h01;
        #1;
        check("R8", {24'd0, y}, 32'h12, "carry-in from status");

        // R9: reset wins over write enable
        @(negedge clk);
        rst = 1'b1; flag_we = 1'b1; op = 4'd9; a = 8'h00;
        @(negedge clk);
        check("R9", {27'd0, status}, 32'd0, "reset priority");
        rst = 1'b0; flag_we = 1'b0;

        // Edge-value sweep over every opcode and both carry-ins
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int c = 0; c < 2; c++)
                        run_ref(4'(o), edges[i], edges[j], c[0]);

        // Random operands
        for (int k = 0; k < 600; k++)
            run_ref(4'($urandom_range(15)), 8'($urandom), 8'($urandom), 1'($urandom));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule